// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable ratio P×N+A. It stands in for the digital side of a dual-modulus frequency synthesizer loop. A prescaler stage divides the input by either P or P+1. The modulus P is 64 or 128, picked by a select input. A 7-bit swallow counter holds the prescaler at P+1 for the first A prescaler periods of each output period. An 11-bit main counter closes the output period after N prescaler periods. One output period therefore lasts A×(P+1) + (N−A)×P = P×N+A input clocks.

At the end of each output period the block emits a one-clock pulse `fp_pulse`. In that same clock it reloads both counters and the modulus from the ratio inputs. A change on the ratio inputs in the middle of a period therefore only takes effect with the following period. The block checks the ratio inputs all the time. A setting with N below 16, or with A not below N, raises `cfg_err` and is never adopted. The block keeps running on the last good setting. The modulus-control line that drives the prescaler is brought out as `mod_ctl`.

Top module: `swallow_divider`

## Requirements
- R1: In steady operation, consecutive `fp_pulse` assertions are exactly P×N+A input clocks apart, where N is `main_ratio` and A is `swallow_ratio`.
- R2: `fp_pulse` is high for exactly one input clock per output period.
- R3: `mod_sel`=1 selects P=64 and `mod_sel`=0 selects P=128.
- R4: Within each output period, `mod_ctl` is high for exactly A×(P+1) input clocks. These clocks start with the first clock of the period. `mod_ctl` then stays low until the period ends, and it is low in the clock where `fp_pulse` is high.
- R5: The ratio inputs are sampled only at the rising edge that ends a period, that is, the edge that closes a clock in which `fp_pulse` is high. A change made mid-period leaves the length of the current period unchanged. The next period uses the new setting.
- R6: `cfg_err` is combinational from the inputs and is high exactly when `main_ratio` < 16 or `swallow_ratio` ≥ `main_ratio`.
- R7: A setting that raises `cfg_err` at a period boundary is ignored. The following periods keep the length given by the previous valid setting.
- R8: `rst` is synchronous and active high, and `fp_pulse` stays low while it is asserted. The last rising edge that samples `rst` high starts the first output period. If the inputs are invalid at that edge, the defaults are used: N=16, A=0, P=64. The first `fp_pulse` is then high after P×N+A−1 further rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| main_ratio | input | 11 | Main counter value N (16 to 2047) |
| swallow_ratio | input | 7 | Swallow counter value A (0 to 127, below N) |
| mod_sel | input | 1 | Prescaler modulus select: 1 gives 64, 0 gives 128 |
| fp_pulse | output | 1 | One-clock pulse at the end of each output period |
| mod_ctl | output | 1 | Modulus control: high while the prescaler divides by P+1 |
| cfg_err | output | 1 | Ratio inputs are outside the allowed range |

## Verification
Periods are measured over a set of settings for both moduli. These include A=0, A=1, A=N−1 and a mid-range A, at the minimum N and just above it. This separates a wrong base modulus from an off-by-one in the swallow window, and shows that a swallow window filling all but one main count still closes correctly. Counting `mod_ctl`-high clocks inside each period separates the right total length from a right total reached by a wrong split between P and P+1 periods. A ratio change made a few clocks into a period must leave that period at the old length, which exposes early loading. Invalid settings must leave two following periods unchanged. Invalid inputs held during reset must produce the default first period.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    localparam int N_W     = 11;
    localparam int A_W     = 7;
    localparam int P_SMALL = 64;
    localparam int P_LARGE = 128;
    localparam int N_MIN   = 16;
    localparam int PSC_W   = $clog2(P_LARGE + 1);

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
        logic           sel;
    } ratio_cfg_t;

    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } mod_e;

    localparam ratio_cfg_t CFG_DEFAULT = '{n: N_W'(N_MIN), a: '0, sel: 1'b1};

    // Legal setting: N at or above the minimum and A strictly below N.
    function automatic logic cfg_valid(ratio_cfg_t c);
        logic [N_W-1:0] a_ext;
        a_ext = {{(N_W - A_W){1'b0}}, c.a};
        return (c.n >= N_W'(N_MIN)) && (a_ext < c.n);
    endfunction

    // Down-counter start value for one prescaler period.
    function automatic logic [PSC_W-1:0] psc_reload(logic sel, mod_e m);
        int base;
        base = sel ? P_SMALL : P_LARGE;
        return PSC_W'(base - 1 + ((m == MOD_PLUS1) ? 1 : 0));
    endfunction

endpackage

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
    import swdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       boundary,
    input  ratio_cfg_t cfg_in,
    output ratio_cfg_t cfg_next,
    output logic       cfg_err
);

    ratio_cfg_t active_q;
    logic       in_ok;

    assign in_ok   = cfg_valid(cfg_in);
    assign cfg_err = !in_ok;

    always_comb begin
        cfg_next = active_q;
        if (rst) begin
            cfg_next = in_ok ? cfg_in : CFG_DEFAULT;
        end else if (boundary && in_ok) begin
            cfg_next = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        active_q <= cfg_next;
    end

    AST_ACTIVE_VALID: assert property (@(posedge clk) disable iff (rst)
        cfg_valid(active_q)); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> $stable(active_q)); // R5

endmodule

// File: rtl/swdiv_psc.sv
module swdiv_psc
    import swdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_next,
    input  mod_e mod_next,
    output logic pre_tc
);

    logic [PSC_W-1:0] cnt_q;

    assign pre_tc = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || pre_tc) begin
            cnt_q <= psc_reload(sel_next, mod_next);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_PSC_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= PSC_W'(P_LARGE)); // R3

    AST_PSC_TC_SPACED: assert property (@(posedge clk) disable iff (rst)
        pre_tc |=> !pre_tc); // R3

endmodule

// File: rtl/swdiv_count.sv
module swdiv_count
    import swdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pre_tc,
    input  ratio_cfg_t cfg_next,
    output logic       boundary,
    output mod_e       mod_now,
    output mod_e       mod_next
);

    logic [N_W-1:0] main_q, main_d;
    logic [A_W-1:0] sw_q,   sw_d;

    assign boundary = !rst && pre_tc && (main_q == N_W'(1));

    always_comb begin
        main_d = main_q;
        sw_d   = sw_q;
        if (rst || boundary) begin
            main_d = cfg_next.n;
            sw_d   = cfg_next.a;
        end else if (pre_tc) begin
            main_d = main_q - 1'b1;
            if (sw_q != '0) begin
                sw_d = sw_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        main_q <= main_d;
        sw_q   <= sw_d;
    end

    assign mod_now  = (sw_q != '0) ? MOD_PLUS1 : MOD_BASE;
    assign mod_next = (sw_d != '0) ? MOD_PLUS1 : MOD_BASE;

    AST_SWALLOW_BELOW_MAIN: assert property (@(posedge clk) disable iff (rst)
        {{(N_W - A_W){1'b0}}, sw_q} < main_q); // R1

    AST_MC_NO_REARM: assert property (@(posedge clk) disable iff (rst)
        (mod_now == MOD_BASE) && !boundary |=> (mod_now == MOD_BASE)); // R4

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swdiv_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] main_ratio,
    input  logic [A_W-1:0] swallow_ratio,
    input  logic           mod_sel,
    output logic           fp_pulse,
    output logic           mod_ctl,
    output logic           cfg_err
);

    ratio_cfg_t cfg_in;
    ratio_cfg_t cfg_next;
    logic       boundary;
    logic       pre_tc;
    mod_e       mod_now;
    mod_e       mod_next;

    assign cfg_in = '{n: main_ratio, a: swallow_ratio, sel: mod_sel};

    swdiv_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .cfg_in   (cfg_in),
        .cfg_next (cfg_next),
        .cfg_err  (cfg_err)
    );

    swdiv_psc u_psc (
        .clk      (clk),
        .rst      (rst),
        .sel_next (cfg_next.sel),
        .mod_next (mod_next),
        .pre_tc   (pre_tc)
    );

    swdiv_count u_count (
        .clk      (clk),
        .rst      (rst),
        .pre_tc   (pre_tc),
        .cfg_next (cfg_next),
        .boundary (boundary),
        .mod_now  (mod_now),
        .mod_next (mod_next)
    );

    assign fp_pulse = boundary;
    assign mod_ctl  = (mod_now == MOD_PLUS1);

    AST_FP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fp_pulse |=> !fp_pulse); // R2

    AST_FP_MC_LOW: assert property (@(posedge clk) disable iff (rst)
        fp_pulse |-> !mod_ctl); // R4

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |-> !fp_pulse); // R8

endmodule

// File: tb/test_swallow_divider.sv
`timescale 1ns/1ps
module test_swallow_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] main_ratio = 11'd16;
    logic [6:0]  swallow_ratio = 7'd0;
    logic        mod_sel = 1'b1;
    logic        fp_pulse, mod_ctl, cfg_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    swallow_divider i_swallow_divider (
        .clk           (clk),
        .rst           (rst),
        .main_ratio    (main_ratio),
        .swallow_ratio (swallow_ratio),
        .mod_sel       (mod_sel),
        .fp_pulse      (fp_pulse),
        .mod_ctl       (mod_ctl),
        .cfg_err       (cfg_err)
    );

    function automatic int exp_len(int n, int a, int s);
        return (s != 0 ? 64 : 128) * n + a;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int n, input int a, input int s);
        main_ratio    = 11'(n);
        swallow_ratio = 7'(a);
        mod_sel       = 1'(s);
    endtask

    // Called at the negedge where fp_pulse was seen high; counts clocks to the next one.
    task automatic measure(input bit chg, input int cn, input int ca, input int cs,
                           output int cyc, output int mcn, output bit mc1, output bit fp1);
        cyc = 0; mcn = 0; mc1 = 1'b0; fp1 = 1'b0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin mc1 = mod_ctl; fp1 = fp_pulse; end
            if (mod_ctl) mcn++;
            if (chg && cyc == 5) drive(cn, ca, cs);
        end while (!(fp_pulse && cyc > 1) && cyc < 6000);
        if (!fp_pulse) chk(1'b0, "R1 watchdog: no fp_pulse", cyc, 0);
    endtask

    localparam int NCFG = 8;
    int cfg_n [NCFG] = '{16, 16, 16, 17, 31, 16, 16, 18};
    int cfg_a [NCFG] = '{0,  1,  15, 9,  30, 0,  15, 5 };
    int cfg_s [NCFG] = '{1,  1,  1,  1,  1,  0,  0,  0 };

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL R1 global watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc, mcn, prev_len, t;
        bit mc1, fp1;

        // R6: range flag sweep while reset holds the datapath (R8: fp low)
        repeat (2) @(negedge clk);
        drive(10, 0, 1);   #1 chk(cfg_err == 1'b1, "R6 N=10", cfg_err, 1);
        drive(15, 0, 0);   #1 chk(cfg_err == 1'b1, "R6 N=15", cfg_err, 1);
        drive(16, 16, 1);  #1 chk(cfg_err == 1'b1, "R6 A=N", cfg_err, 1);
        drive(20, 127, 1); #1 chk(cfg_err == 1'b1, "R6 A>N", cfg_err, 1);
        drive(16, 15, 1);  #1 chk(cfg_err == 1'b0, "R6 A=N-1", cfg_err, 0);
        drive(2047, 127, 0); #1 chk(cfg_err == 1'b0, "R6 max", cfg_err, 0);
        @(negedge clk);
        chk(fp_pulse == 1'b0, "R8 fp low in reset", fp_pulse, 0);

        // R8: first period after release
        drive(cfg_n[0], cfg_a[0], cfg_s[0]);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!fp_pulse && cyc < 6000);
        t = exp_len(cfg_n[0], cfg_a[0], cfg_s[0]);
        chk(cyc == t - 1, "R8 first period", cyc, t - 1);

        measure(1'b0, 0, 0, 0, cyc, mcn, mc1, fp1);
        chk(cyc == t, "R1 period cfg0", cyc, t);
        chk(fp1 == 1'b0, "R2 single-cycle fp", fp1, 0);
        prev_len = t;

        for (int i = 1; i < NCFG; i++) begin
            // R5: mid-period change must not alter the period in progress
            measure(1'b1, cfg_n[i], cfg_a[i], cfg_s[i], cyc, mcn, mc1, fp1);
            chk(cyc == prev_len, "R5 old ratio kept", cyc, prev_len);
            t = exp_len(cfg_n[i], cfg_a[i], cfg_s[i]);
            measure(1'b0, 0, 0, 0, cyc, mcn, mc1, fp1);
            chk(cyc == t, cfg_s[i] ? "R1 R3 period P=64" : "R1 R3 period P=128", cyc, t);
            chk(mcn == cfg_a[i] * ((cfg_s[i] != 0 ? 64 : 128) + 1), "R4 mod_ctl clocks",
                mcn, cfg_a[i] * ((cfg_s[i] != 0 ? 64 : 128) + 1));
            chk(mc1 == (cfg_a[i] != 0), "R4 mod_ctl at start", mc1, cfg_a[i] != 0);
            chk(fp1 == 1'b0, "R2 single-cycle fp", fp1, 0);
            prev_len = t;
        end

        // R7: invalid settings ignored
        measure(1'b1, 10, 3, 1, cyc, mcn, mc1, fp1);
        chk(cfg_err == 1'b1, "R6 flag N=10", cfg_err, 1);
        chk(cyc == prev_len, "R7 N<16 ignored (current)", cyc, prev_len);
        measure(1'b0, 0, 0, 0, cyc, mcn, mc1, fp1);
        chk(cyc == prev_len, "R7 N<16 ignored (next)", cyc, prev_len);
        measure(1'b1, 16, 16, 1, cyc, mcn, mc1, fp1);
        chk(cyc == prev_len, "R7 A>=N ignored (current)", cyc, prev_len);
        measure(1'b0, 0, 0, 0, cyc, mcn, mc1, fp1);
        chk(cyc == prev_len, "R7 A>=N ignored (next)", cyc, prev_len);

        // R8: invalid inputs during reset give defaults N=16 A=0 P=64
        @(negedge clk);
        rst = 1'b1;
        drive(5, 0, 0);
        repeat (3) @(negedge clk);
        chk(fp_pulse == 1'b0, "R8 fp low in reset", fp_pulse, 0);
        rst = 1'b0;
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!fp_pulse && cyc < 6000);
        chk(cyc == 1023, "R8 default first period", cyc, 1023);
        measure(1'b0, 0, 0, 0, cyc, mcn, mc1, fp1);
        chk(cyc == 1024, "R8 default period", cyc, 1024);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule